// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block turns the addressing fields of a load, store or branch into addresses. The offset is either a zero-extended 12-bit immediate or a register value shifted left or right by a 5-bit amount. The block adds it to the base or subtracts it from the base. The base is either the base register value or, for PC-relative accesses, the instruction address plus an 8-byte pipeline bias. Three indexing forms choose which sum becomes the access address and whether the base register is updated:

- pre-indexed: the sum is the access address and the base is left alone;
- pre-indexed with update: the sum is the access address and is also written back;
- post-indexed: the untouched base is the access address and the sum is written back.

The block computes a branch target from a signed 24-bit word offset in parallel. A word access whose address is not word aligned raises an error and cancels the base update.

The register file and the memory port sit outside the block. A request is presented for one cycle with `req_valid`. The registered result appears on the next cycle with `rsp_valid`.

Top module: `ldst_agen`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `wb_en` and `misalign` are 0.
- R2: A request accepted with `req_valid`=1 at a rising edge produces its result, with `rsp_valid`=1, after the next rising edge; requests may arrive on back-to-back cycles.
- R3: Pre-indexed form (`post_idx`=0, `wb_req`=0): `eff_addr` = base ± offset and `wb_en`=0.
- R4: Pre-indexed with update (`post_idx`=0, `wb_req`=1): `eff_addr` = base ± offset, `wb_en`=1 and `wb_val` equals `eff_addr`.
- R5: Post-indexed form (`post_idx`=1): `eff_addr` = unmodified base, `wb_en`=1 and `wb_val` = base ± offset; `wb_req` has no effect in this form.
- R6: With `off_sel_reg`=0 the offset is `off_imm` zero-extended; with `off_sel_reg`=1 it is `off_reg` shifted by `shamt`, left when `shift_dir`=0 and logically right when `shift_dir`=1.
- R7: `off_neg`=1 subtracts the offset from the base; `off_neg`=0 adds it.
- R8: With `pc_rel`=1 the base is `instr_addr`+8 and `wb_en` is 0 whatever `wb_req` and `post_idx` say.
- R9: `br_target` = `instr_addr` + 8 + sign-extended (`br_off` × 4); with `is_branch`=1, `wb_en` and `misalign` are 0.
- R10: A word access (`byte_acc`=0) whose `eff_addr` bits [1:0] are not 00 sets `misalign`=1 and forces `wb_en`=0; a byte access (`byte_acc`=1) never sets `misalign`.
- R11: In a cycle with `rsp_valid`=0, `wb_en` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| instr_addr | input | 32 | Address of the current instruction |
| off_imm | input | 12 | Immediate offset magnitude |
| off_reg | input | 32 | Offset register value |
| off_sel_reg | input | 1 | 1 selects shifted register offset, 0 the immediate |
| shift_dir | input | 1 | 0 shift left, 1 logical shift right |
| shamt | input | 5 | Shift amount |
| off_neg | input | 1 | 1 subtract offset, 0 add |
| post_idx | input | 1 | 1 post-indexed form |
| wb_req | input | 1 | Update request for the pre-indexed form |
| byte_acc | input | 1 | 1 byte access, 0 word access |
| pc_rel | input | 1 | 1 uses instruction address plus 8 as base |
| is_branch | input | 1 | Request is a branch |
| br_off | input | 24 | Signed branch word offset |
| rsp_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective access address |
| wb_en | output | 1 | Base register update enable |
| wb_val | output | 32 | Value to write into the base register |
| br_target | output | 32 | Branch target address |
| misalign | output | 1 | Word access not word aligned |

## Verification
The bench targets the post-indexed case with a shifted register offset. A design that swapped the pre and post sums would put 1100 on the address instead of 1000. It drives PC-relative requests with `wb_req` set, where a design that kept the update would corrupt the base, and a leaky bias would be off by 8. It sends negative branch offsets and the full 4095-byte immediate downward, which expose missing sign extension or a wrong subtract. It also sends misaligned word accesses next to the same addresses as byte accesses. A design that failed to cancel the update, or that flagged byte accesses, would show the wrong `wb_en` or `misalign` there.

// File: rtl/agen_pkg.sv
// Package: shared constants and types of the address generator.
// Assumes a byte-addressed space and 4-byte words.
package agen_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_LSBS  = $clog2(WORD_BYTES);

    // Indexing form derived from the post/update selectors.
    typedef enum logic [1:0] {
        FORM_PRE    = 2'd0,
        FORM_PRE_WB = 2'd1,
        FORM_POST   = 2'd2
    } idx_form_t;
endpackage

// File: rtl/agen_offset.sv
// Offset unit: selects the zero-extended immediate or the shifted register
// as the unsigned offset magnitude. Assumes shamt < AW.
module agen_offset #(
    parameter int unsigned AW    = 32,
    parameter int unsigned IMM_W = 12,
    parameter int unsigned SH_W  = 5
) (
    input  logic [IMM_W-1:0] off_imm,
    input  logic [AW-1:0]    off_reg,
    input  logic             off_sel_reg,
    input  logic             shift_dir,
    input  logic [SH_W-1:0]  shamt,
    output logic [AW-1:0]    off_mag
);
    localparam int unsigned PAD_W = AW - IMM_W;

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] reg_shifted;

    // Zero-extend the immediate to the address width.
    always_comb begin
        imm_ext = {{PAD_W{1'b0}}, off_imm};
    end

    // Shift the register operand in the requested direction.
    always_comb begin
        if (shift_dir) begin
            reg_shifted = off_reg >> shamt;
        end else begin
            reg_shifted = off_reg << shamt;
        end
    end

    // Pick the offset source.
    always_comb begin
        off_mag = off_sel_reg ? reg_shifted : imm_ext;
    end
endmodule

// File: rtl/agen_index.sv
// Index unit: chooses the base (register or biased instruction address),
// applies the signed offset and maps the indexing form onto the access
// address and the update value. PC-relative requests never update.
module agen_index #(
    parameter int unsigned AW      = 32,
    parameter int unsigned PC_BIAS = 8
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] instr_addr,
    input  logic [AW-1:0] off_mag,
    input  logic          off_neg,
    input  logic          post_idx,
    input  logic          wb_req,
    input  logic          pc_rel,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] upd_val,
    output logic          upd_want
);
    import agen_pkg::*;

    localparam logic [AW-1:0] BIAS = AW'(PC_BIAS);

    logic [AW-1:0] base_sel;
    logic [AW-1:0] sum;
    idx_form_t     form;

    // Base source: register, or instruction address plus pipeline bias.
    always_comb begin
        base_sel = pc_rel ? (instr_addr + BIAS) : base_val;
    end

    // Add or subtract the offset magnitude.
    always_comb begin
        sum = off_neg ? (base_sel - off_mag) : (base_sel + off_mag);
    end

    // Decode the indexing form from the two selectors.
    always_comb begin
        if (post_idx) begin
            form = FORM_POST;
        end else if (wb_req) begin
            form = FORM_PRE_WB;
        end else begin
            form = FORM_PRE;
        end
    end

    // Map the form onto address, update value and update request.
    always_comb begin
        upd_val = sum;
        unique case (form)
            FORM_POST: begin
                addr     = base_sel;
                upd_want = !pc_rel;
            end
            FORM_PRE_WB: begin
                addr     = sum;
                upd_want = !pc_rel;
            end
            default: begin
                addr     = sum;
                upd_want = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agen_branch.sv
// Branch unit: scales the signed word offset by 4, sign-extends it and adds
// it to the instruction address plus the pipeline bias. Assumes AW >= BR_W+2.
module agen_branch #(
    parameter int unsigned AW      = 32,
    parameter int unsigned BR_W    = 24,
    parameter int unsigned PC_BIAS = 8
) (
    input  logic [AW-1:0]   instr_addr,
    input  logic [BR_W-1:0] br_off,
    output logic [AW-1:0]   target
);
    localparam int unsigned EXT_W = AW - BR_W - 2;
    localparam logic [AW-1:0] BIAS = AW'(PC_BIAS);

    logic [AW-1:0] disp;

    // Scale to bytes and sign-extend to the address width.
    always_comb begin
        disp = {{EXT_W{br_off[BR_W-1]}}, br_off, 2'b00};
    end

    // Add the displacement to the biased instruction address.
    always_comb begin
        target = instr_addr + BIAS + disp;
    end
endmodule

// File: rtl/ldst_agen.sv
// Top: load/store and branch address generator with one register stage.
// Combines the offset, index and branch units, checks word alignment,
// cancels the base update on errors and branches, and registers the result.
// Assumes requests are single-cycle strobes; no back-pressure exists.
module ldst_agen #(
    parameter int unsigned AW      = 32,
    parameter int unsigned IMM_W   = 12,
    parameter int unsigned BR_W    = 24,
    parameter int unsigned PC_BIAS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    base_val,
    input  logic [AW-1:0]    instr_addr,
    input  logic [IMM_W-1:0] off_imm,
    input  logic [AW-1:0]    off_reg,
    input  logic             off_sel_reg,
    input  logic             shift_dir,
    input  logic [4:0]       shamt,
    input  logic             off_neg,
    input  logic             post_idx,
    input  logic             wb_req,
    input  logic             byte_acc,
    input  logic             pc_rel,
    input  logic             is_branch,
    input  logic [BR_W-1:0]  br_off,
    output logic             rsp_valid,
    output logic [AW-1:0]    eff_addr,
    output logic             wb_en,
    output logic [AW-1:0]    wb_val,
    output logic [AW-1:0]    br_target,
    output logic             misalign
);
    import agen_pkg::*;

    logic [AW-1:0] off_mag;
    logic [AW-1:0] addr_c;
    logic [AW-1:0] upd_val_c;
    logic          upd_want_c;
    logic [AW-1:0] target_c;
    logic          mis_c;
    logic          wb_c;

    agen_offset #(.AW(AW), .IMM_W(IMM_W), .SH_W(5)) u_off (
        .off_imm     (off_imm),
        .off_reg     (off_reg),
        .off_sel_reg (off_sel_reg),
        .shift_dir   (shift_dir),
        .shamt       (shamt),
        .off_mag     (off_mag)
    );

    agen_index #(.AW(AW), .PC_BIAS(PC_BIAS)) u_idx (
        .base_val   (base_val),
        .instr_addr (instr_addr),
        .off_mag    (off_mag),
        .off_neg    (off_neg),
        .post_idx   (post_idx),
        .wb_req     (wb_req),
        .pc_rel     (pc_rel),
        .addr       (addr_c),
        .upd_val    (upd_val_c),
        .upd_want   (upd_want_c)
    );

    agen_branch #(.AW(AW), .BR_W(BR_W), .PC_BIAS(PC_BIAS)) u_br (
        .instr_addr (instr_addr),
        .br_off     (br_off),
        .target     (target_c)
    );

    // Alignment check for word accesses; branches make no data access.
    always_comb begin
        mis_c = !is_branch && !byte_acc && (addr_c[WORD_LSBS-1:0] != '0);
    end

    // Base update survives only for aligned, non-branch requests.
    always_comb begin
        wb_c = upd_want_c && !mis_c && !is_branch;
    end

    // Result register; flags drop when no request, data holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            wb_en     <= 1'b0;
            misalign  <= 1'b0;
            eff_addr  <= '0;
            wb_val    <= '0;
            br_target <= '0;
        end else begin
            rsp_valid <= req_valid;
            wb_en     <= req_valid && wb_c;
            misalign  <= req_valid && mis_c;
            if (req_valid) begin
                eff_addr  <= addr_c;
                wb_val    <= upd_val_c;
                br_target <= target_c;
            end
        end
    end

    // R2: every request yields a result one cycle later.
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4: a pre-indexed update writes the access address back.
    a_r4_wb_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wb_en && !$past(post_idx)) |-> (wb_val == eff_addr));

    // R5: post-indexed register-based access uses the base untouched.
    a_r5_post_base: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(post_idx) && !$past(pc_rel) && !$past(is_branch))
        |-> (eff_addr == $past(base_val)));

    // R8: PC-relative requests never update the base.
    a_r8_pcrel_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(pc_rel)) |-> !wb_en);

    // R9: branches raise neither update nor alignment error.
    a_r9_branch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(is_branch)) |-> (!wb_en && !misalign));

    // R9: branch target keeps the instruction address word phase.
    a_r9_target_phase: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (br_target[1:0] == $past(instr_addr[1:0])));

    // R10: an alignment error cancels the update.
    a_r10_mis_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> !wb_en);

    // R10: byte accesses are never misaligned.
    a_r10_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(byte_acc)) |-> !misalign);

    // R11: flags are quiet without a result.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!wb_en && !misalign));
endmodule

// File: tb/sim_ldst_agen.sv
// Scoreboard bench: a driver task computes expected results from the
// requirements and queues them; a monitor pops and compares each result.
module sim_ldst_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] instr_addr = '0;
    logic [11:0] off_imm = '0;
    logic [31:0] off_reg = '0;
    logic        off_sel_reg = 1'b0;
    logic        shift_dir = 1'b0;
    logic [4:0]  shamt = '0;
    logic        off_neg = 1'b0;
    logic        post_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic        byte_acc = 1'b0;
    logic        pc_rel = 1'b0;
    logic        is_branch = 1'b0;
    logic [23:0] br_off = '0;
    logic        rsp_valid;
    logic [31:0] eff_addr;
    logic        wb_en;
    logic [31:0] wb_val;
    logic [31:0] br_target;
    logic        misalign;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        bit          cmp_addr;
        logic [31:0] addr;
        logic        wbe;
        logic [31:0] wbv;
        logic [31:0] bt;
        logic        mis;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    ldst_agen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_val(base_val), .instr_addr(instr_addr), .off_imm(off_imm),
        .off_reg(off_reg), .off_sel_reg(off_sel_reg), .shift_dir(shift_dir),
        .shamt(shamt), .off_neg(off_neg), .post_idx(post_idx), .wb_req(wb_req),
        .byte_acc(byte_acc), .pc_rel(pc_rel), .is_branch(is_branch),
        .br_off(br_off), .rsp_valid(rsp_valid), .eff_addr(eff_addr),
        .wb_en(wb_en), .wb_val(wb_val), .br_target(br_target),
        .misalign(misalign)
    );

    task automatic check(input string tag, input bit ok, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: present one request and queue its expected result.
    task automatic send(input string tag, input logic [31:0] b, input logic [31:0] ia,
                        input logic [11:0] imm, input logic [31:0] oreg,
                        input bit sel, input bit dir, input logic [4:0] sa,
                        input bit neg, input bit post, input bit wbr, input bit byt,
                        input bit pcr, input bit br, input logic [23:0] boff);
        exp_t e;
        logic [31:0] mag, base, sum;
        @(negedge clk);
        base_val = b; instr_addr = ia; off_imm = imm; off_reg = oreg;
        off_sel_reg = sel; shift_dir = dir; shamt = sa; off_neg = neg;
        post_idx = post; wb_req = wbr; byte_acc = byt; pc_rel = pcr;
        is_branch = br; br_off = boff; req_valid = 1'b1;
        mag  = sel ? (dir ? (oreg >> sa) : (oreg << sa)) : {20'd0, imm};
        base = pcr ? ia + 32'd8 : b;
        sum  = neg ? base - mag : base + mag;
        e.tag = tag;
        e.cmp_addr = !br;
        e.addr = post ? base : sum;
        e.mis  = !br && !byt && (e.addr[1:0] != 2'b00);
        e.wbe  = !br && !pcr && (post || wbr) && !e.mis;
        e.wbv  = sum;
        e.bt   = ia + 32'd8 + {{6{boff[23]}}, boff, 2'b00};
        sb.push_back(e);
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected result", 1'b0, 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.cmp_addr) check({e.tag, " addr"}, eff_addr == e.addr, eff_addr, e.addr);
                check({e.tag, " wb_en"}, wb_en == e.wbe, 32'(wb_en), 32'(e.wbe));
                if (e.wbe) check({e.tag, " wb_val"}, wb_val == e.wbv, wb_val, e.wbv);
                check({e.tag, " target"}, br_target == e.bt, br_target, e.bt);
                check({e.tag, " misalign"}, misalign == e.mis, 32'(misalign), 32'(e.mis));
            end
        end
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 rsp_valid", rsp_valid == 1'b0, 32'(rsp_valid), 32'd0);
        check("R1 wb_en", wb_en == 1'b0, 32'(wb_en), 32'd0);
        check("R1 misalign", misalign == 1'b0, 32'(misalign), 32'd0);
        rst_n = 1'b1;

        // Back-to-back stream (R2).
        send("R5 R6 post lsl", 32'd1000, 32'd0, 12'd0, 32'd25, 1, 0, 5'd2, 0, 1, 0, 0, 0, 0, 24'd0);
        send("R3 pre imm", 32'h2000, 32'h100, 12'h10, 32'd0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 0, 24'd0);
        send("R4 R7 pre wb sub", 32'd2012, 32'd0, 12'd4, 32'd0, 0, 0, 5'd0, 1, 0, 1, 0, 0, 0, 24'd0);
        send("R6 lsr", 32'h4000, 32'd0, 12'hFFF, 32'h100, 1, 1, 5'd4, 0, 0, 1, 0, 0, 0, 24'd0);
        send("R5 post wb_req ignored", 32'h3000, 32'd0, 12'h20, 32'd0, 0, 0, 5'd0, 1, 1, 0, 0, 0, 0, 24'd0);
        send("R8 pcrel wb_req", 32'hDEAD0000, 32'd1000, 12'd52, 32'd0, 0, 0, 5'd0, 0, 0, 1, 0, 1, 0, 24'd0);
        send("R8 R7 pcrel max back", 32'd0, 32'h10000, 12'd4095, 32'd0, 0, 0, 5'd0, 1, 0, 0, 1, 1, 0, 24'd0);
        send("R8 pcrel post", 32'h55, 32'h2000, 12'd4, 32'd0, 0, 0, 5'd0, 0, 1, 0, 0, 1, 0, 24'd0);
        send("R9 branch fwd", 32'h1, 32'd1000, 12'd1, 32'd0, 0, 0, 5'd0, 0, 1, 1, 0, 0, 1, 24'd23);
        send("R9 branch back", 32'h3, 32'd1000, 12'd0, 32'd0, 0, 0, 5'd0, 0, 0, 1, 0, 0, 1, 24'hFFFFFE);
        send("R9 branch min", 32'd0, 32'h0400_0000, 12'd0, 32'd0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 1, 24'h800000);
        send("R10 word mis wb", 32'h1001, 32'd0, 12'd0, 32'd0, 0, 0, 5'd0, 0, 0, 1, 0, 0, 0, 24'd0);
        send("R10 byte ok wb", 32'h1001, 32'd0, 12'd0, 32'd0, 0, 0, 5'd0, 0, 0, 1, 1, 0, 0, 24'd0);
        send("R10 post mis base", 32'h2002, 32'd0, 12'd4, 32'd0, 0, 0, 5'd0, 0, 1, 0, 0, 0, 0, 24'd0);
        send("R10 R6 mis via shift", 32'h8000, 32'd0, 12'd0, 32'h3, 1, 0, 5'd0, 0, 0, 0, 0, 0, 0, 24'd0);
        @(negedge clk);
        req_valid = 1'b0;

        // Drain, then idle quiet (R11).
        @(negedge clk);
        @(negedge clk);
        check("R2 queue drained", sb.size() == 0, 32'(sb.size()), 32'd0);
        check("R11 rsp_valid idle", rsp_valid == 1'b0, 32'(rsp_valid), 32'd0);
        check("R11 wb_en idle", wb_en == 1'b0, 32'(wb_en), 32'd0);
        check("R11 misalign idle", misalign == 1'b0, 32'(misalign), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule